// File: doc/BRIEF.md
# Command Packet Method Sequencer

This block sits behind a command fetcher and turns a stream of 32-bit command-list words into individual register-write transactions. Each packet opens with a header word that names a base method, a subchannel, an argument count and an addressing mode. The block then consumes the argument words that follow, if there are any. For every argument it emits one write carrying a method address, the subchannel, the data word and the number of parameters of the packet still to come. Downstream engines use that count to tell when a multi-word call is complete.

Four addressing modes are supported. The method can advance with every argument, stay fixed, or advance once after the first argument and then stay. The fourth mode is an immediate form in which the header itself carries a 13-bit data value and no argument words follow. A malformed header raises a one-cycle error pulse and is dropped. Both the input and the output use a valid/ready handshake. The output is one register stage, and the input is stalled while that stage is full and not being drained.

Top module: `pb_method_seq`

## Requirements
- R1: A header word is split as method in bits 12:0, subchannel in bits 15:13, count (or immediate data) in bits 28:16 and mode in bits 31:29.
- R2: Mode 1 (advancing) writes argument i to method base+i, wrapping modulo 2^13.
- R3: Mode 3 (fixed) writes every argument to the base method.
- R4: Mode 5 (advance-once) writes the first argument to the base method and each later argument to base+1.
- R5: Mode 4 (immediate) produces exactly one write whose data is bits 28:16 of the header, zero-extended, with a remaining count of 0. It consumes no argument word.
- R6: The remaining-parameter field of argument i is count−i−1, so the last argument carries 0.
- R7: A mode-5 header with a count of 0 produces no write and pulses errFlag for one cycle.
- R8: A header with any mode other than 1, 3, 4 or 5 produces no write and pulses errFlag for one cycle. The next word is decoded as a header.
- R9: A mode-1 or mode-3 header with a count of 0 produces no write and no error. The next word is decoded as a header.
- R10: While outValid is high and outReady is low, outValid and all output fields hold steady and inReady is low.
- R11: After reset, outValid and errFlag are low, inReady is high and the first word is decoded as a header.
- R12: Arguments are consumed in order with no gaps. The word after a packet's last argument is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Command word present |
| inWord | input | 32 | Command word (header or argument) |
| inReady | output | 1 | Word accepted on this edge when high with inValid |
| outValid | output | 1 | Write transaction present |
| outReady | input | 1 | Downstream accepts the transaction |
| outMethod | output | 13 | Target method address |
| outSubch | output | 3 | Subchannel |
| outData | output | 32 | Write data |
| outRemain | output | 13 | Parameters of the packet still to come |
| errFlag | output | 1 | One-cycle pulse on a rejected header |

## Verification
A word accepted on an edge produces its write in the output register on that same edge, so the write is visible one cycle after acceptance. A rejected header shows errFlag during the cycle that follows its acceptance edge. The bench drives inputs shortly after the rising edge and samples on the falling edge. It logs every output handshake and every error pulse that way and compares them afterwards with a list that its own packet model builds, so the checks do not depend on exact cycle placement under backpressure. The stall test holds outReady low for several cycles and verifies at falling edges that the pending write stays frozen and that the input is refused.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;
  parameter int WORD_W   = 32;
  parameter int METHOD_W = 13;
  parameter int SUBCH_W  = 3;
  parameter int COUNT_W  = 13;
  parameter int MODE_W   = 3;
  localparam int SUBCH_LSB = METHOD_W;
  localparam int COUNT_LSB = METHOD_W + SUBCH_W;
  localparam int MODE_LSB  = COUNT_LSB + COUNT_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_STEP = 3'd1,
    MODE_HOLD = 3'd3,
    MODE_IMM  = 3'd4,
    MODE_ONCE = 3'd5
  } mode_e;

  typedef struct packed {
    logic takeHdr;
    logic emitArg;
    logic emitImm;
    logic drainOut;
  } strobe_t;
endpackage

// File: rtl/pbseq_ctrl.sv
module pbseq_ctrl
  import pbseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic              outValid,
  input  logic              outReady,
  input  logic              argLast,
  output logic              inReady,
  output strobe_t           strb,
  output logic              errFlag
);
  typedef enum logic {ST_HDR, ST_ARG} state_e;
  state_e state;

  logic               accept;
  logic               badHdr;
  logic [MODE_W-1:0]  hMode;
  logic [COUNT_W-1:0] hCount;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;
  assign hMode   = inWord[MODE_LSB +: MODE_W];
  assign hCount  = inWord[COUNT_LSB +: COUNT_W];

  always_comb begin
    strb          = '0;
    strb.drainOut = outValid && outReady;
    badHdr        = 1'b0;
    if (accept) begin
      if (state == ST_HDR) begin
        case (hMode)
          MODE_IMM:             strb.emitImm = 1'b1;
          MODE_STEP, MODE_HOLD: strb.takeHdr = (hCount != '0);
          MODE_ONCE: begin
            if (hCount != '0) strb.takeHdr = 1'b1;
            else              badHdr       = 1'b1;
          end
          default:              badHdr = 1'b1;
        endcase
      end else begin
        strb.emitArg = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HDR;
      errFlag <= 1'b0;
    end else begin
      errFlag <= badHdr;
      if (strb.takeHdr)                     state <= ST_ARG;
      else if (strb.emitArg && argLast)     state <= ST_HDR;
    end
  end

  // R7 R8
  err_after_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(accept) && $past(state == ST_HDR));

  // R12
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeHdr, strb.emitArg, strb.emitImm}));

  // R10
  no_take_while_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !(strb.emitArg || strb.emitImm || strb.takeHdr));
endmodule

// File: rtl/pbseq_dp.sv
module pbseq_dp
  import pbseq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [WORD_W-1:0]   inWord,
  output logic                argLast,
  output logic                outValid,
  output logic [METHOD_W-1:0] outMethod,
  output logic [SUBCH_W-1:0]  outSubch,
  output logic [WORD_W-1:0]   outData,
  output logic [COUNT_W-1:0]  outRemain
);
  logic [METHOD_W-1:0] baseM;
  logic [SUBCH_W-1:0]  subch;
  logic [COUNT_W-1:0]  cnt;
  logic [MODE_W-1:0]   mode;
  logic [COUNT_W-1:0]  idx;
  logic [METHOD_W-1:0] offs;

  assign argLast = (idx == cnt - 1'b1);

  always_comb begin
    case (mode)
      MODE_STEP: offs = idx[METHOD_W-1:0];
      MODE_ONCE: offs = (idx == '0) ? '0 : METHOD_W'(1);
      default:   offs = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseM <= '0; subch <= '0; cnt <= '0; mode <= '0; idx <= '0;
      outValid <= 1'b0; outMethod <= '0; outSubch <= '0;
      outData <= '0; outRemain <= '0;
    end else begin
      if (strb.takeHdr) begin
        baseM <= inWord[METHOD_W-1:0];
        subch <= inWord[SUBCH_LSB +: SUBCH_W];
        cnt   <= inWord[COUNT_LSB +: COUNT_W];
        mode  <= inWord[MODE_LSB +: MODE_W];
        idx   <= '0;
      end
      if (strb.emitArg) begin
        outValid  <= 1'b1;
        outMethod <= baseM + offs;
        outSubch  <= subch;
        outData   <= inWord;
        outRemain <= cnt - idx - 1'b1;
        idx       <= idx + 1'b1;
      end else if (strb.emitImm) begin
        outValid  <= 1'b1;
        outMethod <= inWord[METHOD_W-1:0];
        outSubch  <= inWord[SUBCH_LSB +: SUBCH_W];
        outData   <= WORD_W'(inWord[COUNT_LSB +: COUNT_W]);
        outRemain <= '0;
      end else if (strb.drainOut) begin
        outValid  <= 1'b0;
      end
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !strb.drainOut) |=> outValid && $stable(outMethod) &&
      $stable(outData) && $stable(outRemain) && $stable(outSubch));

  // R5
  imm_zero_remain_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitImm |=> outValid && (outRemain == '0));

  // R6
  last_zero_remain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitArg && argLast) |=> (outRemain == '0));
endmodule

// File: rtl/pb_method_seq.sv
module pb_method_seq
  import pbseq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [WORD_W-1:0]   inWord,
  output logic                inReady,
  output logic                outValid,
  input  logic                outReady,
  output logic [METHOD_W-1:0] outMethod,
  output logic [SUBCH_W-1:0]  outSubch,
  output logic [WORD_W-1:0]   outData,
  output logic [COUNT_W-1:0]  outRemain,
  output logic                errFlag
);
  strobe_t strb;
  logic    argLast;

  pbseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outReady(outReady), .argLast(argLast),
    .inReady(inReady), .strb(strb), .errFlag(errFlag)
  );

  pbseq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inWord(inWord),
    .argLast(argLast), .outValid(outValid), .outMethod(outMethod),
    .outSubch(outSubch), .outData(outData), .outRemain(outRemain)
  );
endmodule

// File: tb/pb_method_seq_tb.sv
module pb_method_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        inReady;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [12:0] outMethod;
  logic [2:0]  outSubch;
  logic [31:0] outData;
  logic [12:0] outRemain;
  logic        errFlag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pb_method_seq u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .outMethod(outMethod), .outSubch(outSubch), .outData(outData),
    .outRemain(outRemain), .errFlag(errFlag)
  );

  function automatic logic [31:0] mkHdr(input int md, input int cn, input int sc, input int mt);
    return {3'(md), 13'(cn), 3'(sc), 13'(mt)};
  endfunction

  localparam int NPKT = 10;
  localparam logic [31:0] PKTS [NPKT] = '{
    mkHdr(1, 4, 2, 13'h0100),  // R2
    mkHdr(3, 3, 1, 13'h0200),  // R3
    mkHdr(5, 5, 0, 13'h0E00),  // R4
    mkHdr(4, 13'h1ABC, 3, 13'h0050), // R5
    mkHdr(1, 3, 5, 13'h1FFE),  // R2 wrap
    mkHdr(5, 1, 6, 13'h0E24),  // R4 single
    mkHdr(3, 0, 1, 13'h0300),  // R9
    mkHdr(0, 2, 1, 13'h0400),  // R8
    mkHdr(5, 0, 2, 13'h0500),  // R7
    mkHdr(4, 0, 7, 13'h0007)   // R5 zero data
  };

  logic [60:0] got [256];
  logic [60:0] exp [256];
  string       expTag [256];
  int gotN = 0, expN = 0, errSeen = 0;

  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      got[gotN] = {outMethod, outSubch, outRemain, outData};
      gotN++;
    end
    if (rstN && errFlag) errSeen++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] argWord(input int k, input int i);
    return 32'hA000_0000 + 32'(k * 256 + i);
  endfunction

  task automatic model(input logic [31:0] h, input int k);
    int md = int'(h[31:29]);
    int cn = int'(h[28:16]);
    logic [12:0] m;
    if (md == 4) begin
      exp[expN] = {h[12:0], h[15:13], 13'd0, 19'd0, h[28:16]};
      expTag[expN] = "R5"; expN++;
    end else if (md == 1 || md == 3 || md == 5) begin
      for (int i = 0; i < cn; i++) begin
        m = h[12:0];
        if (md == 1) m = m + 13'(i);
        if (md == 5 && i > 0) m = m + 13'd1;
        exp[expN] = {m, h[15:13], 13'(cn - i - 1), argWord(k, i)};
        expTag[expN] = (md == 1) ? "R2 R6" : (md == 3) ? "R3 R6" : "R4 R6";
        expN++;
      end
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    inValid = 1'b1;
    inWord  = w;
    do @(negedge clk); while (!inReady);
    @(posedge clk); #2;
    inValid = 1'b0;
  endtask

  task automatic sendPkt(input logic [31:0] h, input int k);
    int md = int'(h[31:29]);
    int cn = int'(h[28:16]);
    sendWord(h);
    if (md == 1 || md == 3 || md == 5)
      for (int i = 0; i < cn; i++) sendWord(argWord(k, i));
  endtask

  task automatic compareAll(input string tag);
    chk(gotN == expN, {tag, " R12 write count"}, 64'(gotN), 64'(expN));
    for (int i = 0; i < expN && i < gotN; i++)
      chk(got[i] == exp[i], {tag, " R1 ", expTag[i]}, 64'(got[i]), 64'(exp[i]));
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [60:0] frozen;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R11
    chk(outValid == 1'b0, "R11 outValid after reset", 64'(outValid), 0);
    chk(errFlag == 1'b0, "R11 errFlag after reset", 64'(errFlag), 0);
    chk(inReady == 1'b1, "R11 inReady after reset", 64'(inReady), 1);
    @(posedge clk); #2;

    // Table walk: all packets back to back
    for (int k = 0; k < NPKT; k++) begin
      model(PKTS[k], k);
      sendPkt(PKTS[k], k);
    end
    repeat (4) @(posedge clk); #2;
    compareAll("table");
    // R7 R8: exactly two rejected headers, R9 adds none
    chk(errSeen == 2, "R7 R8 R9 error pulses", 64'(errSeen), 2);

    // R8 then R12: bad header followed directly by a valid immediate header
    gotN = 0; expN = 0; errSeen = 0;
    sendWord(mkHdr(7, 1, 0, 13'h0001));
    model(mkHdr(4, 13'h0123, 2, 13'h0042), 20);
    sendWord(mkHdr(4, 13'h0123, 2, 13'h0042));
    repeat (3) @(posedge clk); #2;
    compareAll("R8 resync");
    chk(errSeen == 1, "R8 single pulse", 64'(errSeen), 1);

    // R10: backpressure holds output and stalls input
    gotN = 0; expN = 0;
    outReady = 1'b0;
    model(mkHdr(1, 3, 4, 13'h0600), 30);
    fork
      sendPkt(mkHdr(1, 3, 4, 13'h0600), 30);
    join_none
    repeat (3) @(negedge clk);
    frozen = {outMethod, outSubch, outRemain, outData};
    chk(outValid == 1'b1, "R10 valid held", 64'(outValid), 1);
    chk(inReady == 1'b0, "R10 input stalled", 64'(inReady), 0);
    repeat (4) @(negedge clk);
    chk({outMethod, outSubch, outRemain, outData} == frozen, "R10 fields stable",
        64'({outMethod, outSubch, outRemain, outData}), 64'(frozen));
    chk(outValid == 1'b1, "R10 valid still held", 64'(outValid), 1);
    @(posedge clk); #2;
    // alternate ready to drain with gaps
    for (int c = 0; c < 12; c++) begin
      outReady = c[0];
      @(posedge clk); #2;
    end
    outReady = 1'b1;
    repeat (4) @(posedge clk); #2;
    compareAll("R10 backpressure");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule